// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Read-During-Write Selection

This block is a two-port synchronous memory. Each port has its own enable, write strobe, address, write data and registered read data. It does nothing between clock edges. On an active edge, an enabled port samples its inputs. It then either reads the addressed word onto its output or writes a word into that location. There is no combinational read path, so every access completes in one clock.

A write on a port also reads the same location. A per-port parameter selects what that port's output shows after a write:
- the word the location now holds,
- the word it held before the edge, or
- the previous output, left untouched.

A parameter selects whether the block acts on the rising or the falling edge of `clk_i`.

When both ports touch the same address on one edge, a fixed rule applies. A reading port sees the contents from before the edge. When both ports write the same address, port A's word is stored.

Top module: `twin_port_sram`

## Requirements
- R1: With the port enabled and its write strobe low, the word at the sampled address appears on that port's read data after the same active edge and stays until the port's next enabled access.
- R2: An enabled write stores the write data at the sampled address, and later reads from either port return it.
- R3: A port built with mode VIEW_NEW (encoding 0) shows, after a write, the word the location holds after that edge.
- R4: A port built with mode VIEW_OLD (encoding 1) shows, after a write, the word the location held before that edge.
- R5: A port built with mode VIEW_HOLD (encoding 2) keeps its read data unchanged across a write.
- R6: With the port enable low, the port neither reads nor writes, and its read data holds regardless of its write strobe, address or data.
- R7: With ACT_RISE=1 the block acts on rising edges of clk_i. With ACT_RISE=0 it acts on falling edges only, and its outputs do not change on rising edges.
- R8: When one port writes a location that the other port reads on the same edge, the reading port returns the word from before the edge.
- R9: When both ports write the same location on one edge, port A's word is stored, and a VIEW_NEW port B shows port A's word.
- R10: While rst_ni is low both read data outputs are zero, and every location reads as zero until first written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the active edge is chosen by ACT_RISE |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_en_i | input | 1 | Port A enable |
| a_we_i | input | 1 | Port A write strobe |
| a_addr_i | input | ADDR_W | Port A address |
| a_wdata_i | input | DATA_W | Port A write data |
| a_rdata_o | output | DATA_W | Port A registered read data |
| b_en_i | input | 1 | Port B enable |
| b_we_i | input | 1 | Port B write strobe |
| b_addr_i | input | ADDR_W | Port B address |
| b_wdata_i | input | DATA_W | Port B write data |
| b_rdata_o | output | DATA_W | Port B registered read data |

## Verification
The bench builds two copies of the block, both with 8-bit words and 16 locations, and drives them with identical stimulus.

The first copy acts on the rising edge, with port A in VIEW_NEW and port B in VIEW_OLD. The second copy acts on the falling edge, with port A in VIEW_HOLD and port B in VIEW_NEW.

Together the two copies cover all three write views and both edge choices. They also cover both roles a VIEW_NEW port can take in a same-address double write: as port A it wins, and as port B it loses to port A.

The second copy is sampled between a falling edge and the next rising edge. This exposes any action taken on the wrong edge.

Random traffic is confined to four addresses so that cross-port collisions occur often.

// File: rtl/twin_port_sram_pkg.sv
package twin_port_sram_pkg;
  typedef enum logic [1:0] {
    VIEW_NEW  = 2'd0,
    VIEW_OLD  = 2'd1,
    VIEW_HOLD = 2'd2
  } wr_view_e;
endpackage

// File: rtl/twin_port_sram_core.sv
module twin_port_sram_core #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_wr_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic              b_wr_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] a_old_o,
  output logic [DATA_W-1:0] b_old_o,
  output logic [DATA_W-1:0] a_post_o,
  output logic [DATA_W-1:0] b_post_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic same_addr;

  assign same_addr = (a_addr_i == b_addr_i);
  assign a_old_o   = mem_q[a_addr_i];
  assign b_old_o   = mem_q[b_addr_i];
  assign a_post_o  = a_wdata_i;
  // port A takes the location on a double write
  assign b_post_o  = (a_wr_i && same_addr) ? a_wdata_i : b_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (b_wr_i) mem_q[b_addr_i] <= b_wdata_i;
      if (a_wr_i) mem_q[a_addr_i] <= a_wdata_i;
    end
  end

  // R2
  a_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_wr_i |=> mem_q[$past(a_addr_i)] == $past(a_wdata_i));

  // R9
  a_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_i && b_wr_i && same_addr) |=> mem_q[$past(b_addr_i)] == $past(a_wdata_i));

  // R2
  b_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_wr_i && !(a_wr_i && same_addr)) |=> mem_q[$past(b_addr_i)] == $past(b_wdata_i));
endmodule

// File: rtl/twin_port_sram_port.sv
module twin_port_sram_port
  import twin_port_sram_pkg::*;
#(
  parameter int       DATA_W = 8,
  parameter wr_view_e MODE   = VIEW_NEW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] post_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] wr_view;
  logic              wr_upd;

  generate
    if (MODE == VIEW_NEW) begin : g_new
      assign wr_view = post_i;
      assign wr_upd  = 1'b1;
    end else if (MODE == VIEW_OLD) begin : g_old
      assign wr_view = old_i;
      assign wr_upd  = 1'b1;
    end else begin : g_hold
      assign wr_view = old_i;
      assign wr_upd  = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (en_i) begin
      if (!we_i) rdata_o <= old_i;
      else if (wr_upd) rdata_o <= wr_view;
    end
  end

  // R6
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rdata_o));

  // R1
  read_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !we_i) |=> rdata_o == $past(old_i));

  generate
    if (MODE == VIEW_NEW) begin : g_new_chk
      // R3
      wr_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && we_i) |=> rdata_o == $past(post_i));
    end else if (MODE == VIEW_OLD) begin : g_old_chk
      // R4
      wr_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && we_i) |=> rdata_o == $past(old_i));
    end else begin : g_hold_chk
      // R5
      wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && we_i) |=> $stable(rdata_o));
    end
  endgenerate
endmodule

// File: rtl/twin_port_sram.sv
module twin_port_sram
  import twin_port_sram_pkg::*;
#(
  parameter int       DATA_W   = 8,
  parameter int       DEPTH    = 16,
  parameter bit       ACT_RISE = 1'b1,
  parameter wr_view_e MODE_A   = VIEW_NEW,
  parameter wr_view_e MODE_B   = VIEW_OLD,
  localparam int      ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_en_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  logic              clk_act;
  logic [DATA_W-1:0] a_old, b_old, a_post, b_post;

  // R7: edge selection folded into one internal clock
  generate
    if (ACT_RISE) begin : g_rise
      assign clk_act = clk_i;
    end else begin : g_fall
      assign clk_act = ~clk_i;
    end
  endgenerate

  twin_port_sram_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_core (
    .clk_i    (clk_act),
    .rst_ni   (rst_ni),
    .a_wr_i   (a_en_i & a_we_i),
    .a_addr_i (a_addr_i),
    .a_wdata_i(a_wdata_i),
    .b_wr_i   (b_en_i & b_we_i),
    .b_addr_i (b_addr_i),
    .b_wdata_i(b_wdata_i),
    .a_old_o  (a_old),
    .b_old_o  (b_old),
    .a_post_o (a_post),
    .b_post_o (b_post)
  );

  twin_port_sram_port #(.DATA_W(DATA_W), .MODE(MODE_A)) u_port_a (
    .clk_i  (clk_act),
    .rst_ni (rst_ni),
    .en_i   (a_en_i),
    .we_i   (a_we_i),
    .old_i  (a_old),
    .post_i (a_post),
    .rdata_o(a_rdata_o)
  );

  twin_port_sram_port #(.DATA_W(DATA_W), .MODE(MODE_B)) u_port_b (
    .clk_i  (clk_act),
    .rst_ni (rst_ni),
    .en_i   (b_en_i),
    .we_i   (b_we_i),
    .old_i  (b_old),
    .post_i (b_post),
    .rdata_o(b_rdata_o)
  );

  // R8: a reading port sees pre-edge contents even when the other port writes there
  cross_read_old_chk: assert property (@(posedge clk_act) disable iff (!rst_ni)
    (a_en_i && !a_we_i && b_en_i && b_we_i && a_addr_i == b_addr_i) |=> a_rdata_o == $past(a_old));

  // R10
  always_comb begin
    if (!rst_ni) begin
      reset_out_chk: assert (a_rdata_o == '0 && b_rdata_o == '0);
    end
  end
endmodule

// File: tb/twin_port_sram_tb.sv
module twin_port_sram_tb;
  import twin_port_sram_pkg::*;

  localparam int DW = 8;
  localparam int DP = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ena, wea, enb, web;
  logic [AW-1:0] aa, ab;
  logic [DW-1:0] wda, wdb;
  logic [DW-1:0] r1a, r1b, r2a, r2b;

  int n_run = 0;
  int n_fail = 0;

  logic [DW-1:0] m [DP];
  logic [DW-1:0] e1a, e1b, e2a, e2b;
  string tag_ovr = "";

  always #5 clk = ~clk;

  twin_port_sram #(.DATA_W(DW), .DEPTH(DP), .ACT_RISE(1'b1),
                   .MODE_A(VIEW_NEW), .MODE_B(VIEW_OLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_en_i(ena), .a_we_i(wea), .a_addr_i(aa), .a_wdata_i(wda), .a_rdata_o(r1a),
    .b_en_i(enb), .b_we_i(web), .b_addr_i(ab), .b_wdata_i(wdb), .b_rdata_o(r1b));

  twin_port_sram #(.DATA_W(DW), .DEPTH(DP), .ACT_RISE(1'b0),
                   .MODE_A(VIEW_HOLD), .MODE_B(VIEW_NEW)) u_dut_neg (
    .clk_i(clk), .rst_ni(rst_n),
    .a_en_i(ena), .a_we_i(wea), .a_addr_i(aa), .a_wdata_i(wda), .a_rdata_o(r2a),
    .b_en_i(enb), .b_we_i(web), .b_addr_i(ab), .b_wdata_i(wdb), .b_rdata_o(r2b));

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] nxt(int mode, logic en, logic we, logic [DW-1:0] old,
                                        logic [DW-1:0] post, logic [DW-1:0] cur);
    if (!en) return cur;
    if (!we) return old;
    if (mode == 0) return post;
    if (mode == 1) return old;
    return cur;
  endfunction

  // requirement tag for a port given this edge's traffic
  function automatic string tag_of(logic en, logic we, logic oth_wr, logic both_wr, int mode);
    if (tag_ovr != "") return tag_ovr;
    if (!en) return "R6";
    if (!we) return oth_wr ? "R8" : "R1";
    if (both_wr) return "R9";
    if (mode == 0) return "R3";
    if (mode == 1) return "R4";
    return "R5";
  endfunction

  // called 2 ns after a rising edge; the falling-edge copy acts next, then the rising one
  task automatic step(logic ea, logic wa, logic [AW-1:0] xa, logic [DW-1:0] da,
                      logic eb, logic wb, logic [AW-1:0] xb, logic [DW-1:0] db);
    logic [DW-1:0] oa, ob, pa, pb;
    logic awr, bwr, same;
    string ta0, ta1, ta2, tb0, tb1, tb2;
    ena = ea; wea = wa; aa = xa; wda = da;
    enb = eb; web = wb; ab = xb; wdb = db;
    awr = ea && wa; bwr = eb && wb; same = (xa == xb);
    oa = m[xa]; ob = m[xb];
    pa = da; pb = (awr && same) ? da : db;
    ta0 = tag_of(ea, wa, bwr && same, awr && bwr && same, 0);
    tb0 = tag_of(eb, wb, awr && same, awr && bwr && same, 1);
    ta2 = tag_of(ea, wa, bwr && same, awr && bwr && same, 2);
    tb2 = tag_of(eb, wb, awr && same, awr && bwr && same, 0);
    ta1 = ta0; tb1 = tb0;
    e1a = nxt(0, ea, wa, oa, pa, e1a);
    e1b = nxt(1, eb, wb, ob, pb, e1b);
    e2a = nxt(2, ea, wa, oa, pa, e2a);
    e2b = nxt(0, eb, wb, ob, pb, e2b);
    if (bwr) m[xb] = db;
    if (awr) m[xa] = da;
    @(negedge clk); #2;
    // R7: falling-edge copy has acted, before any rising edge
    chk({"R7/", ta2}, "neg copy port A", r2a, e2a);
    chk({"R7/", tb2}, "neg copy port B", r2b, e2b);
    @(posedge clk); #2;
    chk(ta1, "rise copy port A", r1a, e1a);
    chk(tb1, "rise copy port B", r1b, e1b);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    ena = 0; wea = 0; enb = 0; web = 0; aa = '0; ab = '0; wda = '0; wdb = '0;
    for (int i = 0; i < DP; i++) m[i] = '0;
    e1a = '0; e1b = '0; e2a = '0; e2b = '0;
    #2;
    // R10: outputs at zero under reset
    chk("R10", "reset port A", r1a, '0);
    chk("R10", "reset port B", r1b, '0);
    chk("R10", "reset neg A", r2a, '0);
    chk("R10", "reset neg B", r2b, '0);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;

    // R10: contents zero after reset
    tag_ovr = "R10";
    for (int i = 0; i < DP; i++) step(1, 0, AW'(i), 8'hff, 1, 0, AW'(DP-1-i), 8'hff);
    tag_ovr = "";

    // writes through each mode
    step(1, 1, 4'd3, 8'h11, 1, 1, 4'd5, 8'h22);
    step(1, 1, 4'd3, 8'h33, 1, 1, 4'd5, 8'h44);
    // R2: readback through the other port
    tag_ovr = "R2";
    step(1, 0, 4'd5, 8'h00, 1, 0, 4'd3, 8'h00);
    tag_ovr = "";
    // R6: disabled write leaves memory and outputs alone
    step(0, 1, 4'd5, 8'hde, 0, 1, 4'd3, 8'had);
    tag_ovr = "R6";
    step(1, 0, 4'd5, 8'h00, 1, 0, 4'd3, 8'h00);
    tag_ovr = "";
    // R8: cross-port read during write
    step(1, 0, 4'd7, 8'h00, 1, 1, 4'd7, 8'h5a);
    step(1, 1, 4'd7, 8'ha5, 1, 0, 4'd7, 8'h00);
    // R9: double write of one location
    step(1, 1, 4'd9, 8'hc3, 1, 1, 4'd9, 8'h3c);
    tag_ovr = "R9";
    step(1, 0, 4'd9, 8'h00, 1, 0, 4'd9, 8'h00);
    tag_ovr = "";

    // random traffic on a narrow address range
    for (int k = 0; k < 600; k++) begin
      step(($urandom % 4) != 0, $urandom % 2, AW'($urandom % 4), DW'($urandom),
           ($urandom % 4) != 0, $urandom % 2, AW'($urandom % 4), DW'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule